// File: doc/BRIEF.md
# Configurable PLD Macrocell

This block is one logic cell of a sum-of-products programmable device. Five product terms arrive already computed by an AND array outside the block. The cell combines a chosen subset of them, and optionally a neighbour's cascade sum, into an OR sum. It passes that sum through an XOR stage for polarity control and can store the result in a register that works in one of several flip-flop or latch modes. The cell drives a pin output, a buried feedback, a cascade sum for the next cell and an inverted foldback term.

The configuration is a static vector `cfg_bits` that packs the `mc_cfg_t` structure. Every field encoding is defined in `mc_pkg`. The cell runs off a fast fabric clock `clk`. The three global clocks and the product-term clock are treated as level signals that are sampled on each fabric edge. A "rising edge" of the selected register clock means that its level was low at one fabric edge and high at the next one, and the register takes the new value on that second fabric edge. Reset and preset act on the outputs in the same cycle and are also captured into the state. There is no streaming data path, so every pin is a plain level signal with no valid/ready handshake and no back-pressure.

Top module: `pld_macrocell`

## Requirements
- R1: `cas_out` is the OR of the product terms whose `sum_mask` bit is set, ORed with `cas_in` when `cas_en` is 1. It has no register delay.
- R2: The XOR result is the sum XORed with a second operand selected by `xor_sel`: 0 gives constant 0, 1 gives constant 1, 2 gives `pt[xor_pt]`. With `out_reg` = 0, `pin_out` equals this XOR result.
- R3: The register data source selected by `d_src` is: 0 the XOR result, 1 `pt[d_pt]`, 2 `pin_in`.
- R4: Mode 0 (D) loads the data on a register clock edge. Mode 1 (T) inverts the state on an edge when the data is 1 and holds it otherwise.
- R5: Mode 2 (JK) uses J = `pt[0]` and K = `pt[1]`. On an edge: J only sets, K only clears, both toggle, neither holds.
- R6: Mode 3 (SR) uses S = `pt[0]` and R = `pt[1]`. On an edge: S only sets, R only clears, and both high or both low hold the state.
- R7: Mode 4 (latch) passes the data through while the selected clock level is high and holds the last value while it is low. The edge and enable logic play no part in this mode.
- R8: `clk_sel` 0, 1 or 2 selects `gclk[0]`, `gclk[1]` or `gclk[2]`, and 3 selects `pt[clk_pt]`. Edge modes update only on a low-to-high transition of the selected level.
- R9: When `ce_en` = 1 and a global clock is selected, an edge while `pt[ce_pt]` = 0 leaves the state unchanged. With the product-term clock the enable is ignored.
- R10: `ar_sel` chooses the reset source: 0 off, 1 `gclr`, 2 `pt[ar_pt]`, 3 either. While reset is active the register output reads 0, even when preset is also active.
- R11: With `ap_en` = 1, `pt[ap_pt]` high and no reset active, the register output reads 1 at once, and the state stays 1 after the preset is released.
- R12: `out_reg` and `fb_reg` independently choose, for `pin_out` and `fb_out`, either the register output (1) or the XOR result (0).
- R13: `fold_out` is always the inverse of `pt[fold_pt]`.
- R14: While `rst_n` is low the state is 0. A selected clock that is already high when reset is released does not count as an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock that samples all levels |
| rst_n | input | 1 | Active-low reset of the cell state |
| cfg_bits | input | CFG_W | Packed static configuration (`mc_cfg_t`) |
| pt | input | NPT | Product terms from the AND array |
| cas_in | input | 1 | Cascade sum from the neighbouring cell |
| pin_in | input | 1 | Value read back from the cell's pin |
| gclk | input | NGCLK | Global clock levels |
| gclr | input | 1 | Global clear level |
| pin_out | output | 1 | Pin output, registered or combinational |
| fb_out | output | 1 | Buried feedback, registered or combinational |
| cas_out | output | 1 | Sum passed to the next cell |
| fold_out | output | 1 | Inverted selected product term |

## Verification
Assertions check on every cycle that reset clears the state, that preset sets it when reset is idle, and that D capture and T toggling happen on a tick. They also check that SR with both inputs high and a closed latch both hold, that a tick only follows a low-to-high level change, and that a gated global clock produces no tick. Only the bench scenarios can show the full chain from configuration to pins. That covers the data-source and XOR polarity choices, the independent routing of pin and feedback, JK behaviour across all input pairs, and latch transparency seen at the outputs. It also covers the absence of a spurious edge after reset and the product-term clock ignoring the enable.

// File: rtl/mc_pkg.sv
`timescale 1ns/1ps
package mc_pkg;
  localparam int unsigned NPT    = 5;
  localparam int unsigned NGCLK  = 3;
  localparam int unsigned PTW    = $clog2(NPT);
  localparam int unsigned JS_IDX = 0;
  localparam int unsigned KR_IDX = 1;

  typedef enum logic [1:0] {XS_ZERO, XS_ONE, XS_PT} mc_xsel_e;
  typedef enum logic [1:0] {DS_XOR, DS_PT, DS_PIN} mc_dsrc_e;
  typedef enum logic [2:0] {FM_D, FM_T, FM_JK, FM_SR, FM_LATCH} mc_mode_e;
  typedef enum logic [1:0] {CK_G0, CK_G1, CK_G2, CK_PT} mc_ksel_e;
  typedef enum logic [1:0] {AR_OFF, AR_GCLR, AR_PT, AR_BOTH} mc_arsel_e;

  typedef struct packed {
    logic [NPT-1:0] sum_mask;
    logic           cas_en;
    mc_xsel_e       xor_sel;
    logic [PTW-1:0] xor_pt;
    mc_dsrc_e       d_src;
    logic [PTW-1:0] d_pt;
    mc_mode_e       mode;
    mc_ksel_e       clk_sel;
    logic [PTW-1:0] clk_pt;
    logic           ce_en;
    logic [PTW-1:0] ce_pt;
    mc_arsel_e      ar_sel;
    logic [PTW-1:0] ar_pt;
    logic           ap_en;
    logic [PTW-1:0] ap_pt;
    logic           out_reg;
    logic           fb_reg;
    logic [PTW-1:0] fold_pt;
  } mc_cfg_t;

  localparam int unsigned CFG_W = $bits(mc_cfg_t);

  // Index into the product terms; an index past the last term reads 0.
  function automatic logic pick_pt(logic [NPT-1:0] v, logic [PTW-1:0] idx);
    logic r;
    r = 1'b0;
    for (int k = 0; k < NPT; k++) begin
      if (idx == PTW'(k)) r = v[k];
    end
    return r;
  endfunction
endpackage

// File: rtl/mc_logic.sv
`timescale 1ns/1ps
module mc_logic
  import mc_pkg::*;
(
  input  mc_cfg_t        cfg,
  input  logic [NPT-1:0] pt,
  input  logic           cas_in,
  input  logic           pin_in,
  output logic           sum_o,
  output logic           xor_o,
  output logic           d_o,
  output logic           j_o,
  output logic           k_o,
  output logic           fold_o
);
  logic [NPT-1:0] masked;
  logic           operand;

  genvar g;
  generate
    for (g = 0; g < NPT; g++) begin : g_mask
      assign masked[g] = pt[g] & cfg.sum_mask[g];
    end
  endgenerate

  assign sum_o = (|masked) | (cfg.cas_en & cas_in);

  always_comb begin
    case (cfg.xor_sel)
      XS_ONE:  operand = 1'b1;
      XS_PT:   operand = pick_pt(pt, cfg.xor_pt);
      default: operand = 1'b0;
    endcase
  end

  assign xor_o = sum_o ^ operand;

  always_comb begin
    case (cfg.d_src)
      DS_PT:   d_o = pick_pt(pt, cfg.d_pt);
      DS_PIN:  d_o = pin_in;
      default: d_o = xor_o;
    endcase
  end

  assign j_o    = pt[JS_IDX];
  assign k_o    = pt[KR_IDX];
  assign fold_o = ~pick_pt(pt, cfg.fold_pt);
endmodule

// File: rtl/mc_ctrl.sv
`timescale 1ns/1ps
module mc_ctrl
  import mc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  mc_cfg_t          cfg,
  input  logic [NPT-1:0]   pt,
  input  logic [NGCLK-1:0] gclk,
  input  logic             gclr,
  output logic             lvl_o,
  output logic             tick_o,
  output logic             ar_o,
  output logic             ap_o
);
  logic prev_q;
  logic ce_ok;
  logic ar_pt_v;

  always_comb begin
    lvl_o = pick_pt(pt, cfg.clk_pt);
    if (cfg.clk_sel != CK_PT) begin
      lvl_o = 1'b0;
      for (int k = 0; k < NGCLK; k++) begin
        if (int'(cfg.clk_sel) == k) lvl_o = gclk[k];
      end
    end
  end

  // Level of the selected clock at the previous fabric edge; starts high so
  // a clock already high at reset release is not taken as an edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= lvl_o;
  end

  assign ce_ok  = (cfg.clk_sel == CK_PT) | ~cfg.ce_en | pick_pt(pt, cfg.ce_pt);
  assign tick_o = lvl_o & ~prev_q & ce_ok;

  assign ar_pt_v = pick_pt(pt, cfg.ar_pt);
  always_comb begin
    case (cfg.ar_sel)
      AR_GCLR: ar_o = gclr;
      AR_PT:   ar_o = ar_pt_v;
      AR_BOTH: ar_o = gclr | ar_pt_v;
      default: ar_o = 1'b0;
    endcase
  end

  assign ap_o = cfg.ap_en & pick_pt(pt, cfg.ap_pt);

  AST_TICK_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> (lvl_o && !$past(lvl_o))); // R8
endmodule

// File: rtl/mc_reg.sv
`timescale 1ns/1ps
module mc_reg
  import mc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  mc_mode_e mode,
  input  logic     lvl,
  input  logic     tick,
  input  logic     ar,
  input  logic     ap,
  input  logic     d,
  input  logic     j,
  input  logic     k,
  output logic     q_o
);
  logic q_r;
  logic nxt;

  always_comb begin
    case (mode)
      FM_T:  nxt = q_r ^ d;
      FM_JK: nxt = (j & k) ? ~q_r : (j ? 1'b1 : (k ? 1'b0 : q_r));
      FM_SR: nxt = (j & ~k) ? 1'b1 : ((k & ~j) ? 1'b0 : q_r);
      default: nxt = d;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= 1'b0;
    end else if (ar) begin
      q_r <= 1'b0;
    end else if (ap) begin
      q_r <= 1'b1;
    end else if (mode == FM_LATCH) begin
      if (lvl) q_r <= d;
    end else if (tick) begin
      q_r <= nxt;
    end
  end

  assign q_o = ar ? 1'b0 : (ap ? 1'b1 : ((mode == FM_LATCH && lvl) ? d : q_r));

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ar |=> (q_r == 1'b0)); // R10
  AST_PRESET_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (ap && !ar) |=> (q_r == 1'b1)); // R11
  AST_D_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == FM_D && tick && !ar && !ap) |=> (q_r == $past(d))); // R4
  AST_T_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == FM_T && tick && d && !ar && !ap) |=> (q_r != $past(q_r))); // R4
  AST_SR_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == FM_SR && tick && j && k && !ar && !ap) |=> $stable(q_r)); // R6
  AST_LATCH_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == FM_LATCH && !lvl && !ar && !ap) |=> $stable(q_r)); // R7
endmodule

// File: rtl/pld_macrocell.sv
`timescale 1ns/1ps
module pld_macrocell
  import mc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_bits,
  input  logic [NPT-1:0]   pt,
  input  logic             cas_in,
  input  logic             pin_in,
  input  logic [NGCLK-1:0] gclk,
  input  logic             gclr,
  output logic             pin_out,
  output logic             fb_out,
  output logic             cas_out,
  output logic             fold_out
);
  mc_cfg_t cfg;
  logic sum_w, xor_w, d_w, j_w, k_w, fold_w;
  logic lvl_w, tick_w, ar_w, ap_w, q_w;

  assign cfg = mc_cfg_t'(cfg_bits);

  mc_logic u_logic (
    .cfg    (cfg),
    .pt     (pt),
    .cas_in (cas_in),
    .pin_in (pin_in),
    .sum_o  (sum_w),
    .xor_o  (xor_w),
    .d_o    (d_w),
    .j_o    (j_w),
    .k_o    (k_w),
    .fold_o (fold_w)
  );

  mc_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .cfg    (cfg),
    .pt     (pt),
    .gclk   (gclk),
    .gclr   (gclr),
    .lvl_o  (lvl_w),
    .tick_o (tick_w),
    .ar_o   (ar_w),
    .ap_o   (ap_w)
  );

  mc_reg u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .mode  (cfg.mode),
    .lvl   (lvl_w),
    .tick  (tick_w),
    .ar    (ar_w),
    .ap    (ap_w),
    .d     (d_w),
    .j     (j_w),
    .k     (k_w),
    .q_o   (q_w)
  );

  assign pin_out  = cfg.out_reg ? q_w : xor_w;
  assign fb_out   = cfg.fb_reg  ? q_w : xor_w;
  assign cas_out  = sum_w;
  assign fold_out = fold_w;

  AST_GATED_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.clk_sel != CK_PT && cfg.ce_en && !pick_pt(pt, cfg.ce_pt)) |-> !tick_w); // R9
endmodule

// File: tb/pld_macrocell_tb.sv
`timescale 1ns/1ps
module pld_macrocell_tb;
  import mc_pkg::*;

  logic             clk = 1'b0;
  logic             rst_n;
  mc_cfg_t          cfg;
  logic [CFG_W-1:0] cfg_bits;
  logic [NPT-1:0]   pt;
  logic             cas_in, pin_in, gclr;
  logic [NGCLK-1:0] gclk;
  logic             pin_out, fb_out, cas_out, fold_out;

  int unsigned n_checks = 0;
  int unsigned n_fail   = 0;
  logic        m_q, m_prev;

  assign cfg_bits = cfg;
  always #10 clk = ~clk;

  pld_macrocell u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_bits(cfg_bits), .pt(pt), .cas_in(cas_in),
    .pin_in(pin_in), .gclk(gclk), .gclr(gclr), .pin_out(pin_out),
    .fb_out(fb_out), .cas_out(cas_out), .fold_out(fold_out)
  );

  task automatic chk(input string tag, input logic got, input logic exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic string mode_tag(mc_mode_e m);
    case (m)
      FM_T:     return "R4";
      FM_JK:    return "R5";
      FM_SR:    return "R6";
      FM_LATCH: return "R7";
      default:  return "R4";
    endcase
  endfunction

  // Inputs are already driven; check outputs, advance the model, move to next negedge.
  task automatic step(input string tag, input bit lit_en = 0, input logic lit = 1'b0);
    logic s, op, x, dv, lv, ce, ar, ap, qv, j, k;
    #2;
    s  = |(pt & cfg.sum_mask) | (cfg.cas_en & cas_in);
    op = (cfg.xor_sel == XS_ONE) ? 1'b1 : (cfg.xor_sel == XS_PT) ? pt[cfg.xor_pt] : 1'b0;
    x  = s ^ op;
    dv = (cfg.d_src == DS_PT) ? pt[cfg.d_pt] : (cfg.d_src == DS_PIN) ? pin_in : x;
    lv = (cfg.clk_sel == CK_PT) ? pt[cfg.clk_pt] : gclk[cfg.clk_sel];
    ce = (cfg.clk_sel == CK_PT) || !cfg.ce_en || pt[cfg.ce_pt];
    ar = (((cfg.ar_sel == AR_GCLR) || (cfg.ar_sel == AR_BOTH)) && gclr) ||
         (((cfg.ar_sel == AR_PT) || (cfg.ar_sel == AR_BOTH)) && pt[cfg.ar_pt]);
    ap = cfg.ap_en && pt[cfg.ap_pt];
    if (!rst_n) qv = 1'b0;
    else qv = ar ? 1'b0 : ap ? 1'b1 : (cfg.mode == FM_LATCH && lv) ? dv : m_q;
    j = pt[0]; k = pt[1];
    chk((tag != "") ? tag : (cfg.out_reg ? mode_tag(cfg.mode) : "R2"), pin_out, cfg.out_reg ? qv : x);
    chk((tag != "") ? tag : "R12", fb_out, cfg.fb_reg ? qv : x);
    chk("R1", cas_out, s);
    chk("R13", fold_out, ~pt[cfg.fold_pt]);
    if (lit_en) chk(tag, pin_out, lit);
    if (!rst_n) begin
      m_q = 1'b0; m_prev = 1'b1;
    end else begin
      if (ar) m_q = 1'b0;
      else if (ap) m_q = 1'b1;
      else if (cfg.mode == FM_LATCH) begin
        if (lv) m_q = dv;
      end else if (lv && !m_prev && ce) begin
        case (cfg.mode)
          FM_T:  m_q = m_q ^ dv;
          FM_JK: m_q = (j && k) ? ~m_q : j ? 1'b1 : k ? 1'b0 : m_q;
          FM_SR: m_q = (j && !k) ? 1'b1 : (k && !j) ? 1'b0 : m_q;
          default: m_q = dv;
        endcase
      end
      m_prev = lv;
    end
    @(negedge clk);
  endtask

  task automatic base_cfg();
    cfg = '0;
    cfg.mode = FM_D; cfg.clk_sel = CK_G0; cfg.ar_sel = AR_OFF;
    cfg.xor_sel = XS_ZERO; cfg.d_src = DS_XOR; cfg.out_reg = 1'b1;
  endtask

  task automatic rand_cfg();
    cfg.sum_mask = NPT'($urandom);
    cfg.cas_en   = 1'($urandom);
    cfg.xor_sel  = mc_xsel_e'($urandom_range(2, 0));
    cfg.xor_pt   = PTW'($urandom_range(NPT-1, 0));
    cfg.d_src    = mc_dsrc_e'($urandom_range(2, 0));
    cfg.d_pt     = PTW'($urandom_range(NPT-1, 0));
    cfg.mode     = mc_mode_e'($urandom_range(4, 0));
    cfg.clk_sel  = mc_ksel_e'($urandom_range(3, 0));
    cfg.clk_pt   = PTW'($urandom_range(NPT-1, 0));
    cfg.ce_en    = 1'($urandom);
    cfg.ce_pt    = PTW'($urandom_range(NPT-1, 0));
    cfg.ar_sel   = mc_arsel_e'($urandom_range(3, 0));
    cfg.ar_pt    = PTW'($urandom_range(NPT-1, 0));
    cfg.ap_en    = 1'($urandom);
    cfg.ap_pt    = PTW'($urandom_range(NPT-1, 0));
    cfg.out_reg  = 1'($urandom);
    cfg.fb_reg   = 1'($urandom);
    cfg.fold_pt  = PTW'($urandom_range(NPT-1, 0));
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    base_cfg();
    rst_n = 1'b0; pt = '0; cas_in = 0; pin_in = 0; gclk = '0; gclr = 0;
    m_q = 0; m_prev = 1;
    @(negedge clk);
    step("R14", 1, 1'b0);
    gclk = '1; pin_in = 1; cfg.d_src = DS_PIN;
    step("R14", 1, 1'b0);
    rst_n = 1'b1;
    step("R14", 1, 1'b0);                  // clock high at release: no edge
    step("R14", 1, 1'b0);

    // R3 / R8: data from the pin, clocked by global clock 2
    cfg.clk_sel = CK_G2; gclk = '0; pin_in = 1;
    step("R8");
    gclk[2] = 1'b1;
    step("R8", 1, 1'b0);
    step("R3", 1, 1'b1);

    // R9: gated global clock ignores an edge, term clock ignores the enable
    cfg.clk_sel = CK_G0; cfg.ce_en = 1; cfg.ce_pt = 3'd4; pt = '0; pin_in = 0; gclk = '0;
    step("R9");
    gclk[0] = 1'b1;
    step("R9");
    step("R9", 1, 1'b1);
    cfg.clk_sel = CK_PT; cfg.clk_pt = 3'd3;
    step("R9");
    pt[3] = 1'b1;
    step("R9");
    step("R9", 1, 1'b0);

    // R6: SR set, then both high holds
    cfg.ce_en = 0; cfg.clk_sel = CK_G0; cfg.mode = FM_SR; pt = '0; gclk = '0;
    step("R6");
    pt = 5'b00001; gclk[0] = 1;
    step("R6");
    gclk[0] = 0;
    step("R6", 1, 1'b1);
    pt = 5'b00011; gclk[0] = 1;
    step("R6");
    step("R6", 1, 1'b1);

    // R10 / R11: reset beats preset, preset alone sets and sticks
    cfg.mode = FM_D; cfg.d_src = DS_XOR; cfg.ar_sel = AR_GCLR; cfg.ap_en = 1; cfg.ap_pt = 3'd2;
    pt = 5'b00100; gclr = 1; gclk = '0;
    step("R10", 1, 1'b0);
    gclr = 0;
    step("R11", 1, 1'b1);
    pt = '0;
    step("R11", 1, 1'b1);

    // R7: latch transparent while high, holds after fall
    cfg.ar_sel = AR_OFF; cfg.ap_en = 0; cfg.mode = FM_LATCH; cfg.clk_sel = CK_G1;
    cfg.d_src = DS_PIN; gclk = 3'b010; pin_in = 0;
    step("R7", 1, 1'b0);
    pin_in = 1;
    step("R7", 1, 1'b1);
    gclk = '0; pin_in = 0;
    step("R7", 1, 1'b1);
    step("R7", 1, 1'b1);

    // R5 directed: JK toggle with both high
    cfg.mode = FM_JK; cfg.clk_sel = CK_G0; pt = 5'b00011; gclk = '0;
    step("R5");
    gclk[0] = 1;
    step("R5");
    step("R5", 1, 1'b0);

    // Random configurations and stimulus
    for (int c = 0; c < 60; c++) begin
      rand_cfg();
      for (int s = 0; s < 40; s++) begin
        pt     = NPT'($urandom);
        cas_in = 1'($urandom);
        pin_in = 1'($urandom);
        gclk   = NGCLK'($urandom);
        gclr   = ($urandom_range(7, 0) == 0);
        step("");
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule